// File: doc/BRIEF.md
# NAND Flash Data-Port Strobe Controller

This block connects a simple request/acknowledge CPU bus to a NAND flash device that has no address pins and shares a 16-bit data bus. Software sends every command, address and data byte of the NAND protocol through one memory-mapped data port. The block turns each CPU access to that port into a single timed read-enable or write-enable pulse on the flash. The pulse width comes from a programmable wait-state count.

Two registers hold the static flash controls. The control register holds the wait-state count, the NAND enable bit, the two active-low chip selects and the active-low write protect. The pin register drives the command latch enable and the address latch enable. It also returns the flash ready/busy line after a two-flop synchronizer. Data-port accesses are ignored while the NAND enable bit is clear. Only one access is in progress at a time, and the acknowledge is held back until the strobe sequence has finished.

Top module: `nand_port_ctrl`

## Requirements
- R1: After reset the following hold. Both strobes are high and both chip selects are high. Write protect is low. The data bus output enable is low. Command and address latch enables are low. The acknowledge is low. The control register reads 0x0300.
- R2: The control register is at 0x01FF8820. It holds the wait count in bits [3:0], the NAND enable in bit 4, the chip selects in bits [9:8] and write protect in bit 11. A read returns these fields with every other bit zero, and the acknowledge comes one cycle after the request is taken.
- R3: Control bits 8 and 9 drive chip select outputs 0 and 1 directly, and control bit 11 drives the write-protect output. These outputs change in the cycle after the register write.
- R4: The pin register is at 0x01FF8828. Bit 0 drives the command latch enable and bit 1 drives the address latch enable. Bit 8 reads the ready input through a two-flop synchronizer, so a read taken in the cycle the input changes still returns the old value.
- R5: With NAND enable set, a read of 0x01FF8824 drives the read strobe low for wait+1 cycles. The acknowledge arrives the cycle after the strobe rises (wait+2 cycles after the request), carrying the data bus value sampled in the last low cycle.
- R6: With NAND enable set, a write to 0x01FF8824 drives the write strobe low for wait+1 cycles with the write data on the bus. The bus output enable is high one cycle before the fall and one cycle after the rise of the strobe. The acknowledge comes wait+3 cycles after the request.
- R7: With NAND enable clear, a data-port access produces no strobe and no bus drive. It is acknowledged one cycle later, and a read returns 0.
- R8: The acknowledge is a one-cycle pulse and the two strobes are never low together. Every strobe is followed by at least one high cycle before the next access starts.
- R9: An access to any other address is acknowledged one cycle later, changes no register and reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, held until acknowledge |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid with acknowledge |
| bus_ack | output | 1 | One-cycle completion pulse |
| flash_rd_n | output | 1 | Flash read enable, active low |
| flash_wr_n | output | 1 | Flash write enable, active low |
| flash_ce_n | output | 2 | Flash chip selects, active low |
| flash_wp_n | output | 1 | Write protect, active low |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_rdy | input | 1 | Ready/busy from flash, asynchronous |
| flash_dq_in | input | 16 | Data bus input |
| flash_dq_out | output | 16 | Data bus output value |
| flash_dq_oe | output | 1 | Data bus output enable |

## Verification
The hardest points to reach are the edges of the wait-state range and a change of the NAND enable bit between two data-port accesses. In those cases the strobe width, the acknowledge latency and the capture cycle all move together. The stimulus mixes directed accesses at wait counts 0 and 15 with a seeded random sequence. That sequence rewrites the control register with random wait and enable values between data-port reads and writes. The bench flash model changes the bus value on every low cycle of the read strobe, so a read captured one cycle early or late gives different data.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  localparam int CTRL_WAIT_LSB = 0;
  localparam int CTRL_EN_BIT   = 4;
  localparam int CTRL_CS_LSB   = 8;
  localparam int CTRL_WP_BIT   = 11;
  localparam int PIN_CLE_BIT   = 0;
  localparam int PIN_ALE_BIT   = 1;
  localparam int PIN_RDY_BIT   = 8;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_ACT   = 3'd1,
    ST_RD_DONE  = 3'd2,
    ST_WR_SETUP = 3'd3,
    ST_WR_ACT   = 3'd4,
    ST_WR_DONE  = 3'd5,
    ST_REG_DONE = 3'd6
  } seq_state_e;
endpackage

// File: rtl/nfc_sync.sv
module nfc_sync #(
  parameter int  STAGES = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/nfc_regs.sv
module nfc_regs
  import nfc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4,
  parameter int CS_N   = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h01FF_8820,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 'h01FF_8828
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rdy_sync,
  output logic [DATA_W-1:0] rd_val,
  output logic [WAIT_W-1:0] wait_cfg,
  output logic              nand_en,
  output logic [CS_N-1:0]   cs_n,
  output logic              wp_n,
  output logic              cle,
  output logic              ale
);
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic              en_q, en_d;
  logic [CS_N-1:0]   cs_q, cs_d;
  logic              wp_q, wp_d;
  logic              cle_q, cle_d;
  logic              ale_q, ale_d;
  logic              hit_ctrl, hit_pin;

  assign hit_ctrl = (addr == CTRL_ADDR);
  assign hit_pin  = (addr == PIN_ADDR);

  always_comb begin
    wait_d = wait_q;
    en_d   = en_q;
    cs_d   = cs_q;
    wp_d   = wp_q;
    cle_d  = cle_q;
    ale_d  = ale_q;
    if (wr_en && hit_ctrl) begin
      wait_d = wdata[CTRL_WAIT_LSB +: WAIT_W];
      en_d   = wdata[CTRL_EN_BIT];
      cs_d   = wdata[CTRL_CS_LSB +: CS_N];
      wp_d   = wdata[CTRL_WP_BIT];
    end
    if (wr_en && hit_pin) begin
      cle_d = wdata[PIN_CLE_BIT];
      ale_d = wdata[PIN_ALE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= '0;
      en_q   <= 1'b0;
      cs_q   <= '1;
      wp_q   <= 1'b0;
      cle_q  <= 1'b0;
      ale_q  <= 1'b0;
    end else if (wr_en) begin
      wait_q <= wait_d;
      en_q   <= en_d;
      cs_q   <= cs_d;
      wp_q   <= wp_d;
      cle_q  <= cle_d;
      ale_q  <= ale_d;
    end
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctrl) begin
      rd_val[CTRL_WAIT_LSB +: WAIT_W] = wait_q;
      rd_val[CTRL_EN_BIT]             = en_q;
      rd_val[CTRL_CS_LSB +: CS_N]     = cs_q;
      rd_val[CTRL_WP_BIT]             = wp_q;
    end else if (hit_pin) begin
      rd_val[PIN_CLE_BIT] = cle_q;
      rd_val[PIN_ALE_BIT] = ale_q;
      rd_val[PIN_RDY_BIT] = rdy_sync;
    end
  end

  assign wait_cfg = wait_q;
  assign nand_en  = en_q;
  assign cs_n     = cs_q;
  assign wp_n     = wp_q;
  assign cle      = cle_q;
  assign ale      = ale_q;
endmodule

// File: rtl/nfc_strobe_seq.sv
module nfc_strobe_seq
  import nfc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic              is_port,
  input  logic              nand_en,
  input  logic [WAIT_W-1:0] wait_cfg,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] flash_din,
  output logic              accept,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_n,
  output logic              wr_n,
  output logic              dq_oe,
  output logic [DATA_W-1:0] dq_out
);
  seq_state_e        state_q, state_d;
  logic [WAIT_W-1:0] cnt_q, cnt_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic [DATA_W-1:0] wdat_q, wdat_d;
  logic              strobe_go;

  assign accept    = (state_q == ST_IDLE) && req;
  assign strobe_go = is_port && nand_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rdata_d = rdata_q;
    wdat_d  = wdat_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req) begin
          if (strobe_go && !we) begin
            state_d = ST_RD_ACT;
            cnt_d   = wait_cfg;
          end else if (strobe_go && we) begin
            state_d = ST_WR_SETUP;
            cnt_d   = wait_cfg;
            wdat_d  = wdata;
          end else begin
            state_d = ST_REG_DONE;
            rdata_d = we ? rdata_q : reg_rdata;
          end
        end
      end
      ST_RD_ACT: begin
        if (cnt_q == '0) begin
          state_d = ST_RD_DONE;
          rdata_d = flash_din;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WR_SETUP: state_d = ST_WR_ACT;
      ST_WR_ACT: begin
        if (cnt_q == '0) state_d = ST_WR_DONE;
        else             cnt_d   = cnt_q - 1'b1;
      end
      ST_RD_DONE, ST_WR_DONE, ST_REG_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdata_q <= '0;
      wdat_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdata_q <= rdata_d;
      wdat_q  <= wdat_d;
    end
  end

  assign ack    = (state_q == ST_RD_DONE) || (state_q == ST_WR_DONE) ||
                  (state_q == ST_REG_DONE);
  assign rd_n   = (state_q != ST_RD_ACT);
  assign wr_n   = (state_q != ST_WR_ACT);
  assign dq_oe  = (state_q == ST_WR_SETUP) || (state_q == ST_WR_ACT) ||
                  (state_q == ST_WR_DONE);
  assign dq_out = wdat_q;
  assign rdata  = rdata_q;
endmodule

// File: rtl/nand_port_ctrl.sv
module nand_port_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 4,
  parameter int CS_N   = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h01FF_8820,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h01FF_8824,
  parameter logic [ADDR_W-1:0] PIN_ADDR  = 'h01FF_8828
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              flash_rd_n,
  output logic              flash_wr_n,
  output logic [CS_N-1:0]   flash_ce_n,
  output logic              flash_wp_n,
  output logic              flash_cle,
  output logic              flash_ale,
  input  logic              flash_rdy,
  input  logic [DATA_W-1:0] flash_dq_in,
  output logic [DATA_W-1:0] flash_dq_out,
  output logic              flash_dq_oe
);
  logic              rst_n_s;
  logic              rdy_sync;
  logic              accept;
  logic              nand_en;
  logic [WAIT_W-1:0] wait_cfg;
  logic [DATA_W-1:0] reg_rdata;
  logic              is_port;

  nfc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_n_s)
  );

  nfc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n_s), .d(flash_rdy), .q(rdy_sync)
  );

  assign is_port = (bus_addr == PORT_ADDR);

  nfc_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W), .CS_N(CS_N),
    .CTRL_ADDR(CTRL_ADDR), .PIN_ADDR(PIN_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(accept && bus_we),
    .addr(bus_addr), .wdata(bus_wdata), .rdy_sync(rdy_sync),
    .rd_val(reg_rdata), .wait_cfg(wait_cfg), .nand_en(nand_en),
    .cs_n(flash_ce_n), .wp_n(flash_wp_n), .cle(flash_cle), .ale(flash_ale)
  );

  nfc_strobe_seq #(.DATA_W(DATA_W), .WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_s),
    .req(bus_req), .we(bus_we), .is_port(is_port),
    .nand_en(nand_en), .wait_cfg(wait_cfg),
    .wdata(bus_wdata), .reg_rdata(reg_rdata), .flash_din(flash_dq_in),
    .accept(accept), .ack(bus_ack), .rdata(bus_rdata),
    .rd_n(flash_rd_n), .wr_n(flash_wr_n),
    .dq_oe(flash_dq_oe), .dq_out(flash_dq_out)
  );
endmodule

// File: rtl/nfc_checker.sv
module nfc_checker #(
  parameter int WAIT_W = 4
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              bus_ack,
  input logic              flash_rd_n,
  input logic              flash_wr_n,
  input logic              flash_dq_oe,
  input logic              nand_en,
  input logic [WAIT_W-1:0] wait_cfg
);
  localparam int CW = WAIT_W + 2;
  logic [CW-1:0] rd_lo, wr_lo;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rd_lo <= '0;
      wr_lo <= '0;
    end else begin
      rd_lo <= flash_rd_n ? '0 : rd_lo + 1'b1;
      wr_lo <= flash_wr_n ? '0 : wr_lo + 1'b1;
    end
  end

  always_comb begin
    if (rst_n_s == 1'b0) begin
      assert_reset_idle_R1: assert (flash_rd_n && flash_wr_n && !flash_dq_oe && !bus_ack);
    end
  end

  assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    !(!flash_rd_n && !flash_wr_n));

  assert_ack_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    bus_ack |=> !bus_ack);

  assert_rd_width_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flash_rd_n) |-> (rd_lo == CW'(wait_cfg) + 1'b1));

  assert_wr_width_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flash_wr_n) |-> (wr_lo == CW'(wait_cfg) + 1'b1));

  assert_oe_setup_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(flash_wr_n) |-> $past(flash_dq_oe));

  assert_oe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(flash_wr_n) |-> flash_dq_oe);

  assert_gated_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ($fell(flash_rd_n) || $fell(flash_wr_n)) |-> nand_en);
endmodule

bind nand_port_ctrl nfc_checker #(.WAIT_W(WAIT_W)) u_chk (
  .clk(clk), .rst_n_s(rst_n_s), .bus_ack(bus_ack),
  .flash_rd_n(flash_rd_n), .flash_wr_n(flash_wr_n),
  .flash_dq_oe(flash_dq_oe), .nand_en(nand_en), .wait_cfg(wait_cfg)
);

// File: tb/nand_port_ctrl_tb.sv
`timescale 1ns/1ps
module nand_port_ctrl_tb;
  localparam logic [31:0] A_CTRL = 32'h01FF_8820;
  localparam logic [31:0] A_PORT = 32'h01FF_8824;
  localparam logic [31:0] A_PIN  = 32'h01FF_8828;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_req, bus_we;
  logic [31:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ack;
  logic        flash_rd_n, flash_wr_n, flash_wp_n, flash_cle, flash_ale;
  logic [1:0]  flash_ce_n;
  logic        flash_rdy;
  logic [15:0] flash_dq_in, flash_dq_out;
  logic        flash_dq_oe;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // access results
  logic [15:0] r_data;
  int r_cyc, r_rdlo, r_wrlo;
  bit r_oe_ok, r_dq_ok;

  // model of registers
  logic [3:0] m_wait;
  logic       m_en, m_wp, m_cle, m_ale;
  logic [1:0] m_cs;

  always #2 clk = ~clk;

  nand_port_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .flash_rd_n(flash_rd_n), .flash_wr_n(flash_wr_n),
    .flash_ce_n(flash_ce_n), .flash_wp_n(flash_wp_n), .flash_cle(flash_cle),
    .flash_ale(flash_ale), .flash_rdy(flash_rdy), .flash_dq_in(flash_dq_in),
    .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ctrl_img();
    logic [15:0] v = '0;
    v[3:0] = m_wait; v[4] = m_en; v[9:8] = m_cs; v[11] = m_wp;
    return v;
  endfunction

  task automatic acc(input bit we, input logic [31:0] a, input logic [15:0] wd,
                     input logic [15:0] base);
    bit prev_wr, prev_oe;
    r_cyc = 0; r_rdlo = 0; r_wrlo = 0; r_oe_ok = 1; r_dq_ok = 1; r_data = 'x;
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = a; bus_wdata = wd;
    prev_wr = flash_wr_n; prev_oe = flash_dq_oe;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      r_cyc++;
      if (!flash_rd_n) begin
        r_rdlo++;
        flash_dq_in = base + 16'(r_rdlo);
      end
      if (!flash_wr_n) begin
        r_wrlo++;
        if (flash_dq_out !== wd || !flash_dq_oe) r_dq_ok = 0;
      end
      if (prev_wr && !flash_wr_n && !prev_oe) r_oe_ok = 0;
      if (!prev_wr && flash_wr_n && !flash_dq_oe) r_oe_ok = 0;
      if (!we && flash_dq_oe) r_oe_ok = 0;
      prev_wr = flash_wr_n; prev_oe = flash_dq_oe;
      if (bus_ack) begin
        r_data = bus_rdata;
        if (!flash_rd_n || !flash_wr_n) r_oe_ok = 0;
        break;
      end
    end
    if (!bus_ack) begin
      fails++;
      $display("FAIL R8 no acknowledge actual=0x0 expected=0x1");
    end
    bus_req = 0;
    @(negedge clk);
    chk(bus_ack == 1'b0, "R8 ack single pulse", bus_ack, 0);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    acc(1, A_CTRL, v, 0);
    m_wait = v[3:0]; m_en = v[4]; m_cs = v[9:8]; m_wp = v[11];
  endtask

  task automatic port_read(input string tag);
    logic [15:0] base = 16'($urandom);
    acc(0, A_PORT, 16'h0, base);
    if (m_en) begin
      chk(r_rdlo == m_wait + 1, {tag, " read strobe width"}, r_rdlo, m_wait + 1);
      chk(r_cyc == m_wait + 2, {tag, " read ack latency"}, r_cyc, m_wait + 2);
      chk(r_data == base + 16'(m_wait) + 16'd1, {tag, " read data capture"}, r_data, base + 16'(m_wait) + 16'd1);
    end else begin
      chk(r_rdlo == 0 && r_cyc == 1, "R7 disabled read no strobe", r_rdlo, 0);
      chk(r_data == 16'h0, "R7 disabled read data", r_data, 0);
    end
  endtask

  task automatic port_write(input string tag);
    logic [15:0] d = 16'($urandom);
    acc(1, A_PORT, d, 0);
    if (m_en) begin
      chk(r_wrlo == m_wait + 1, {tag, " write strobe width"}, r_wrlo, m_wait + 1);
      chk(r_cyc == m_wait + 3, {tag, " write ack latency"}, r_cyc, m_wait + 3);
      chk(r_oe_ok && r_dq_ok, {tag, " bus enable and data"}, {r_oe_ok, r_dq_ok}, 2'b11);
    end else begin
      chk(r_wrlo == 0 && r_cyc == 1 && r_oe_ok, "R7 disabled write no strobe", r_wrlo, 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    flash_rdy = 0; flash_dq_in = 0;
    m_wait = 0; m_en = 0; m_cs = 2'b11; m_wp = 0; m_cle = 0; m_ale = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(flash_rd_n && flash_wr_n, "R1 strobes high", {flash_rd_n, flash_wr_n}, 2'b11);
    chk(flash_ce_n == 2'b11 && flash_wp_n == 0, "R1 selects and protect", {flash_ce_n, flash_wp_n}, 3'b110);
    chk(!flash_dq_oe && !flash_cle && !flash_ale && !bus_ack, "R1 bus and latches idle",
        {flash_dq_oe, flash_cle, flash_ale, bus_ack}, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    acc(0, A_CTRL, 0, 0);
    chk(r_data == 16'h0300 && r_cyc == 1, "R1 R2 control reset readback", r_data, 16'h0300);

    // R2 and R3 field positions
    wr_ctrl(16'hFFFF);
    acc(0, A_CTRL, 0, 0);
    chk(r_data == 16'h0B1F, "R2 control read mask", r_data, 16'h0B1F);
    chk(flash_ce_n == 2'b11 && flash_wp_n == 1, "R3 outputs follow bits", {flash_ce_n, flash_wp_n}, 3'b111);
    wr_ctrl(16'h0210);
    chk(flash_ce_n == 2'b10 && flash_wp_n == 0, "R3 select 0 low, protect low", {flash_ce_n, flash_wp_n}, 3'b100);
    wr_ctrl(16'h0910);
    chk(flash_ce_n == 2'b01 && flash_wp_n == 1, "R3 select 1 low, protect high", {flash_ce_n, flash_wp_n}, 3'b011);

    // R5/R6 at wait extremes
    wr_ctrl(16'h0810);
    port_read("R5 wait0");
    port_write("R6 wait0");
    wr_ctrl(16'h081F);
    port_read("R5 wait15");
    port_write("R6 wait15");

    // R7 disabled port
    wr_ctrl(16'h080F);
    port_read("R7");
    port_write("R7");
    chk(flash_rd_n && flash_wr_n && !flash_dq_oe, "R7 no strobe after access", {flash_rd_n, flash_wr_n, flash_dq_oe}, 3'b110);

    // R9 unmapped
    acc(1, 32'h01FF_8830, 16'hFFFF, 0);
    chk(r_cyc == 1, "R9 unmapped write ack", r_cyc, 1);
    acc(0, A_CTRL, 0, 0);
    chk(r_data == ctrl_img(), "R9 unmapped write ignored", r_data, ctrl_img());
    acc(0, 32'h0000_0024, 0, 0);
    chk(r_data == 0 && r_cyc == 1, "R9 unmapped read zero", r_data, 0);

    // R4 pin register
    acc(1, A_PIN, 16'h0001, 0);
    chk(flash_cle == 1 && flash_ale == 0, "R4 command latch enable", {flash_cle, flash_ale}, 2'b10);
    acc(1, A_PIN, 16'h0002, 0);
    chk(flash_cle == 0 && flash_ale == 1, "R4 address latch enable", {flash_cle, flash_ale}, 2'b01);
    m_cle = 0; m_ale = 1;
    @(negedge clk);
    flash_rdy = 1;
    bus_req = 1; bus_we = 0; bus_addr = A_PIN;
    @(negedge clk);
    chk(bus_ack && bus_rdata == 16'h0002, "R4 ready not yet visible", bus_rdata, 16'h0002);
    bus_req = 0;
    repeat (3) @(negedge clk);
    acc(0, A_PIN, 0, 0);
    chk(r_data == 16'h0102, "R4 ready visible after sync", r_data, 16'h0102);

    // random mix
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 2) begin
        logic [15:0] v = 16'($urandom);
        if ($urandom_range(0, 3) != 0) v[4] = 1'b1;
        wr_ctrl(v);
      end else if (op < 5) begin
        port_read("R5 random");
      end else if (op < 8) begin
        port_write("R6 random");
      end else if (op == 8) begin
        acc(0, A_CTRL, 0, 0);
        chk(r_data == ctrl_img(), "R2 random control readback", r_data, ctrl_img());
      end else begin
        logic [15:0] v = 16'($urandom);
        acc(1, A_PIN, v, 0);
        m_cle = v[0]; m_ale = v[1];
        chk(flash_cle == m_cle && flash_ale == m_ale, "R4 random latch enables",
            {flash_cle, flash_ale}, {m_cle, m_ale});
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule